// File: doc/BRIEF.md
# Parallel NOR Flash Command Engine

This block is a synthesizable model of a parallel NOR flash part that answers the classic two-cycle command protocol. A simple slave bus carries an address, a 32-bit write word, write and read strobes, an access size of 1, 2 or 4 bytes and a big-endian strap. Behind the bus sits a small byte array. Writes on the bus are either commands or data, depending on the state of a write-cycle state machine. Reads are answered from the array, from an 8-bit status byte, from an identifier table or from a parameter-query table, depending on that state. Every program, erase and buffered write finishes at once and reports ready. A write-protect strap makes the array read-only. A non-secure strobe, honoured when the secure option is on, limits an access to plain array reads.

The state machine has ten states. ARRAY, STATUS and IDENT accept a first-cycle command:
- 0x10 or 0x40 goes to PROG_ARM.
- 0x20 or 0x28 goes to ERASE_ARM.
- 0x60 goes to LOCK_ARM.
- 0x70 goes to STATUS.
- 0x90 goes to IDENT.
- 0x98 goes to QUERY.
- 0xE8 goes to BUF_COUNT.
- 0x50 clears the status byte and goes to ARRAY.
- Every other value goes to ARRAY.

The remaining states take one write each:
- PROG_ARM stores the data and goes to STATUS.
- ERASE_ARM erases on 0xD0 and goes to STATUS. Any other value goes to ARRAY.
- LOCK_ARM goes to STATUS on 0xD0 or 0x01, and to ARRAY otherwise.
- QUERY goes to ARRAY on any write.
- BUF_COUNT loads the count and goes to BUF_DATA.
- BUF_DATA stores one word per write. It goes to BUF_CONFIRM once the count has run out.
- BUF_CONFIRM goes to STATUS on 0xD0 and to ARRAY otherwise.

Top module: `nor_flash_engine`

## Requirements
- R1: After reset, the block is in ARRAY. The status byte is 0x80, every array byte is 0xFF and rdata_o is 0.
- R2: Command 0x10 or 0x40 arms a program. The next write stores its data at its address with the current size and byte order, and status bit 7 is set. With wprot_i high, nothing is stored and status bits 7 and 4 are set. Either way the block then reads status.
- R3: Command 0x20 or 0x28 arms an erase.
  - A following 0xD0 sets every byte of the SEC_BYTES-aligned sector holding the address to 0xFF and sets status bit 7.
  - With wprot_i high, the 0xD0 leaves the array unchanged and sets status bits 7 and 5.
  - Any other second value returns to ARRAY with no erase.
- R4: Command 0x50 sets the status byte to 0x00 and returns to ARRAY.
- R5: Command 0x70 enters STATUS. Commands 0xFF, 0xF0, 0x00 and any unlisted value return to ARRAY without touching the status byte.
- R6: Command 0x60 arms lock setup. A second write of 0xD0 or 0x01 sets status bit 7 and enters STATUS. Any other value returns to ARRAY.
- R7: Command 0xE8 sets status bit 7 and starts a buffered write.
  - The next write gives a count N, taken from its low 8*DEV_BYTES bits.
  - The next N+1 writes are stored like programs.
  - A write of 0xD0 then sets bit 7 and enters STATUS. Any other value returns to ARRAY, and the stored data stays.
- R8: In STATUS and in every armed or buffered state, a read returns the status byte in byte lanes 0, DEV_BYTES, 2*DEV_BYTES and so on, up to the access size. All other lanes are zero.
- R9: In IDENT, with offset = address >> log2(BANK_BYTES), a read returns MFR_ID at offset 0, DEV_ID at offset 1 and 0x00 elsewhere. The byte is placed in the lanes given by R8.
- R10: In QUERY, the same offset selects one table byte, placed in the lanes given by R8:
  - offsets 0x10, 0x11 and 0x12 give 0x51, 0x52 and 0x59;
  - offset 0x13 gives 0x01;
  - offset 0x27 gives log2(DEPTH);
  - offset 0x2C gives 0x01;
  - every other offset gives 0x00.

  Any write in QUERY returns to ARRAY.
- R11: With SECURE_EN set and nsec_i high, a read returns array data whatever the state, and a write changes neither the array, the state nor the status byte.
- R12: Array accesses of 2 or 4 bytes cover addresses addr..addr+size-1. With big_end_i low, byte addr+k is lane k. With big_end_i high, byte addr+k is lane size-1-k.
- R13: rdata_o is registered. It takes the response on the clock edge that samples re_i high and holds its value while re_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Byte address, AW = log2(DEPTH) |
| wdata_i | input | 32 | Write word: a command in its low byte, a count or data |
| we_i | input | 1 | Write strobe, one access per high cycle |
| re_i | input | 1 | Read strobe |
| size_i | input | 3 | Access size in bytes: 1, 2 or 4 |
| big_end_i | input | 1 | Byte-order strap for array accesses |
| wprot_i | input | 1 | Array write-protect strap |
| nsec_i | input | 1 | Marks the access as non-secure |
| rdata_o | output | 32 | Registered read response |

## Verification
A write acts on the clock edge that samples we_i. The state, the status byte and the array are new from that edge, so a read strobed in any later cycle sees the result. A read response appears on rdata_o one edge after re_i is sampled. The bench updates its reference model at the same edge as the design and compares at the following falling edge. Between reads, the bench also checks on every falling edge that rdata_o still holds the value the model last predicted.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;

    typedef enum logic [3:0] {
        ST_ARRAY, ST_STATUS, ST_IDENT, ST_QUERY, ST_PROG_ARM,
        ST_ERASE_ARM, ST_LOCK_ARM, ST_BUF_COUNT, ST_BUF_DATA, ST_BUF_CONFIRM
    } fsm_state_t;

    typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_IDENT, SRC_QUERY} rd_src_t;

    localparam logic [7:0] OP_PROG_A   = 8'h10;
    localparam logic [7:0] OP_PROG_B   = 8'h40;
    localparam logic [7:0] OP_ERASE_A  = 8'h20;
    localparam logic [7:0] OP_ERASE_B  = 8'h28;
    localparam logic [7:0] OP_CLEAR    = 8'h50;
    localparam logic [7:0] OP_LOCK     = 8'h60;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_BUFFER   = 8'hE8;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_LOCK_ALT = 8'h01;

    localparam logic [7:0] SR_READY     = 8'h80;
    localparam logic [7:0] SR_ERASE_ERR = 8'h20;
    localparam logic [7:0] SR_PROG_ERR  = 8'h10;

    // Place one byte in every device lane that fits in the access size
    function automatic logic [31:0] lane_fill(input logic [7:0] b, input int dev_bytes,
                                              input logic [2:0] size);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < 4; k++) begin
            if ((k % dev_bytes) == 0 && k < int'(size)) r[8*k +: 8] = b;
        end
        return r;
    endfunction

endpackage

// File: rtl/nor_byte_store.sv
module nor_byte_store #(
    parameter int DEPTH     = 256,
    parameter int SEC_BYTES = 16,
    localparam int AW       = $clog2(DEPTH),
    localparam int SEC_SH   = $clog2(SEC_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    input  logic [2:0]    size,
    input  logic          big_end,
    input  logic          prog_en,
    input  logic          erase_en,
    output logic [31:0]   rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (erase_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((AW'(i) >> SEC_SH) == (addr >> SEC_SH)) mem[i] <= 8'hFF;
            end
        end else if (prog_en) begin
            for (int k = 0; k < 4; k++) begin
                if (k < int'(size)) begin
                    if (big_end) mem[addr + AW'(k)] <= wdata[8*(int'(size)-1-k) +: 8];
                    else         mem[addr + AW'(k)] <= wdata[8*k +: 8];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < int'(size)) begin
                if (big_end) rdata[8*(int'(size)-1-k) +: 8] = mem[addr + AW'(k)];
                else         rdata[8*k +: 8]                = mem[addr + AW'(k)];
            end
        end
    end

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_flash_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [7:0]       cmd,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             wprot,
    output logic             prog_en,
    output logic             erase_en,
    output rd_src_t          rd_src,
    output logic [7:0]       status
);

    fsm_state_t       state_q, state_d;
    logic [7:0]       status_q, status_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_ARRAY;
            status_q <= SR_READY;
            cnt_q    <= '0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
            cnt_q    <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        cnt_d    = cnt_q;
        if (wr_stb) begin
            unique case (state_q)
                ST_ARRAY, ST_STATUS, ST_IDENT: begin
                    case (cmd)
                        OP_PROG_A, OP_PROG_B:   state_d = ST_PROG_ARM;
                        OP_ERASE_A, OP_ERASE_B: state_d = ST_ERASE_ARM;
                        OP_CLEAR: begin
                            status_d = 8'h00;
                            state_d  = ST_ARRAY;
                        end
                        OP_LOCK:   state_d = ST_LOCK_ARM;
                        OP_STATUS: state_d = ST_STATUS;
                        OP_IDENT:  state_d = ST_IDENT;
                        OP_QUERY:  state_d = ST_QUERY;
                        OP_BUFFER: begin
                            status_d = status_q | SR_READY;
                            state_d  = ST_BUF_COUNT;
                        end
                        default:   state_d = ST_ARRAY;
                    endcase
                end
                ST_QUERY: state_d = ST_ARRAY;
                ST_PROG_ARM: begin
                    status_d = status_q | SR_READY | (wprot ? SR_PROG_ERR : 8'h00);
                    state_d  = ST_STATUS;
                end
                ST_ERASE_ARM: begin
                    if (cmd == OP_CONFIRM) begin
                        status_d = status_q | SR_READY | (wprot ? SR_ERASE_ERR : 8'h00);
                        state_d  = ST_STATUS;
                    end else begin
                        state_d = ST_ARRAY;
                    end
                end
                ST_LOCK_ARM: begin
                    if (cmd == OP_CONFIRM || cmd == OP_LOCK_ALT) begin
                        status_d = status_q | SR_READY;
                        state_d  = ST_STATUS;
                    end else begin
                        state_d = ST_ARRAY;
                    end
                end
                ST_BUF_COUNT: begin
                    cnt_d   = cnt_in;
                    state_d = ST_BUF_DATA;
                end
                ST_BUF_DATA: begin
                    if (wprot) status_d = status_q | SR_PROG_ERR;
                    if (cnt_q == '0) state_d = ST_BUF_CONFIRM;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                ST_BUF_CONFIRM: begin
                    if (cmd == OP_CONFIRM) begin
                        status_d = status_q | SR_READY;
                        state_d  = ST_STATUS;
                    end else begin
                        state_d = ST_ARRAY;
                    end
                end
                default: state_d = ST_ARRAY;
            endcase
        end
    end

    always_comb begin
        status   = status_q;
        prog_en  = wr_stb && !wprot && (state_q == ST_PROG_ARM || state_q == ST_BUF_DATA);
        erase_en = wr_stb && !wprot && (state_q == ST_ERASE_ARM) && (cmd == OP_CONFIRM);
        unique case (state_q)
            ST_ARRAY: rd_src = SRC_ARRAY;
            ST_IDENT: rd_src = SRC_IDENT;
            ST_QUERY: rd_src = SRC_QUERY;
            default:  rd_src = SRC_STATUS;
        endcase
    end

    AST_PROG_READY: assert property (@(posedge clk) disable iff (!rst_n) (wr_stb && state_q == ST_PROG_ARM) |=> (status_q[7] && state_q == ST_STATUS)); // R2
    AST_ERASE_PROT: assert property (@(posedge clk) disable iff (!rst_n) (wr_stb && wprot && state_q == ST_ERASE_ARM && cmd == OP_CONFIRM) |=> (status_q[5] && status_q[7])); // R3
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (wr_stb && cmd == OP_CLEAR && (state_q == ST_ARRAY || state_q == ST_STATUS || state_q == ST_IDENT)) |=> (status_q == 8'h00 && state_q == ST_ARRAY)); // R4
    AST_CONFIRM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_BUF_CONFIRM) |-> ($past(state_q) == ST_BUF_DATA || $past(state_q) == ST_BUF_CONFIRM)); // R7

endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux
    import nor_flash_pkg::*;
#(
    parameter int         DEPTH      = 256,
    parameter int         DEV_BYTES  = 1,
    parameter int         BANK_BYTES = 4,
    parameter logic [7:0] MFR_ID     = 8'h89,
    parameter logic [7:0] DEV_ID     = 8'h18,
    localparam int        AW         = $clog2(DEPTH),
    localparam int        BANK_SH    = $clog2(BANK_BYTES)
) (
    input  rd_src_t       src,
    input  logic [AW-1:0] addr,
    input  logic [2:0]    size,
    input  logic [31:0]   arr_data,
    input  logic [7:0]    status,
    output logic [31:0]   resp
);

    logic [AW-1:0] off;
    logic [7:0]    id_byte, qry_byte;

    always_comb begin
        off = addr >> BANK_SH;

        if (off == AW'(0))      id_byte = MFR_ID;
        else if (off == AW'(1)) id_byte = DEV_ID;
        else                    id_byte = 8'h00;

        case (off)
            AW'(16): qry_byte = 8'h51;
            AW'(17): qry_byte = 8'h52;
            AW'(18): qry_byte = 8'h59;
            AW'(19): qry_byte = 8'h01;
            AW'(39): qry_byte = 8'(AW);
            AW'(44): qry_byte = 8'h01;
            default: qry_byte = 8'h00;
        endcase

        unique case (src)
            SRC_ARRAY:  resp = arr_data;
            SRC_IDENT:  resp = lane_fill(id_byte, DEV_BYTES, size);
            SRC_QUERY:  resp = lane_fill(qry_byte, DEV_BYTES, size);
            default:    resp = lane_fill(status, DEV_BYTES, size);
        endcase
    end

endmodule

// File: rtl/nor_flash_engine.sv
module nor_flash_engine
    import nor_flash_pkg::*;
#(
    parameter int         DEPTH      = 256,
    parameter int         SEC_BYTES  = 16,
    parameter int         DEV_BYTES  = 1,
    parameter int         BANK_BYTES = 4,
    parameter bit         SECURE_EN  = 1'b1,
    parameter logic [7:0] MFR_ID     = 8'h89,
    parameter logic [7:0] DEV_ID     = 8'h18,
    localparam int        AW         = $clog2(DEPTH),
    localparam int        CNT_W      = 8 * DEV_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic [31:0]   wdata_i,
    input  logic          we_i,
    input  logic          re_i,
    input  logic [2:0]    size_i,
    input  logic          big_end_i,
    input  logic          wprot_i,
    input  logic          nsec_i,
    output logic [31:0]   rdata_o
);

    logic        nsec_blk, wr_stb, prog_en, erase_en;
    rd_src_t     rd_src_w, src_eff;
    logic [7:0]  status_w;
    logic [31:0] arr_data, resp;

    assign nsec_blk = SECURE_EN && nsec_i;
    assign wr_stb   = we_i && !nsec_blk;
    assign src_eff  = nsec_blk ? SRC_ARRAY : rd_src_w;

    nor_cmd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .cmd      (wdata_i[7:0]),
        .cnt_in   (wdata_i[CNT_W-1:0]),
        .wprot    (wprot_i),
        .prog_en  (prog_en),
        .erase_en (erase_en),
        .rd_src   (rd_src_w),
        .status   (status_w)
    );

    nor_byte_store #(.DEPTH(DEPTH), .SEC_BYTES(SEC_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr_i),
        .wdata    (wdata_i),
        .size     (size_i),
        .big_end  (big_end_i),
        .prog_en  (prog_en),
        .erase_en (erase_en),
        .rdata    (arr_data)
    );

    nor_read_mux #(
        .DEPTH(DEPTH), .DEV_BYTES(DEV_BYTES), .BANK_BYTES(BANK_BYTES),
        .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
    ) u_rmux (
        .src      (src_eff),
        .addr     (addr_i),
        .size     (size_i),
        .arr_data (arr_data),
        .status   (status_w),
        .resp     (resp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata_o <= '0;
        else if (re_i) rdata_o <= resp;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !re_i |=> $stable(rdata_o)); // R13
    AST_NSEC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (we_i && nsec_blk) |=> ($stable(status_w) && $stable(rd_src_w))); // R11

endmodule

// File: tb/sim_nor_flash_engine.sv
module sim_nor_flash_engine;

    localparam int M_ARR = 0, M_STAT = 1, M_ID = 2, M_QRY = 3, M_PROG = 4;
    localparam int M_ERASE = 5, M_LOCK = 6, M_BCNT = 7, M_BDATA = 8, M_BCONF = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0, re = 1'b0, be = 1'b0, wp = 1'b0, ns = 1'b0;
    logic [2:0]  size = 3'd4;
    logic [31:0] rdata_o;

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    logic [7:0]  mm [256];
    int          mode;
    logic [7:0]  st;
    int          cnt;
    logic [31:0] exp_rd = '0;

    always #2 clk = ~clk;

    nor_flash_engine u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
        .re_i(re), .size_i(size), .big_end_i(be), .wprot_i(wp), .nsec_i(ns),
        .rdata_o(rdata_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] fill(input logic [7:0] b, input int s);
        logic [31:0] r = '0;
        for (int k = 0; k < s; k++) r[8*k +: 8] = b;
        return r;
    endfunction

    function automatic void mstore(input logic [7:0] a, input logic [31:0] d, input int s);
        for (int k = 0; k < s; k++)
            mm[8'(a + k)] = be ? d[8*(s-1-k) +: 8] : d[8*k +: 8];
    endfunction

    function automatic logic [31:0] model_rd(input logic [7:0] a, input int s, input bit nsec);
        logic [31:0] r = '0;
        int          o = int'(a) / 4;
        logic [7:0]  b;
        if (nsec || mode == M_ARR) begin
            for (int k = 0; k < s; k++)
                if (be) r[8*(s-1-k) +: 8] = mm[8'(a + k)];
                else    r[8*k +: 8]       = mm[8'(a + k)];
        end else if (mode == M_ID) begin
            b = (o == 0) ? 8'h89 : (o == 1) ? 8'h18 : 8'h00;
            r = fill(b, s);
        end else if (mode == M_QRY) begin
            case (o)
                16: b = 8'h51; 17: b = 8'h52; 18: b = 8'h59; 19: b = 8'h01;
                39: b = 8'd8;  44: b = 8'h01; default: b = 8'h00;
            endcase
            r = fill(b, s);
        end else begin
            r = fill(st, s);
        end
        return r;
    endfunction

    function automatic void model_wr(input logic [7:0] a, input logic [31:0] d, input int s, input bit nsec);
        logic [7:0] c = d[7:0];
        if (nsec) return;
        case (mode)
            M_ARR, M_STAT, M_ID: begin
                case (c)
                    8'h10, 8'h40: mode = M_PROG;
                    8'h20, 8'h28: mode = M_ERASE;
                    8'h50: begin st = 8'h00; mode = M_ARR; end
                    8'h60: mode = M_LOCK;
                    8'h70: mode = M_STAT;
                    8'h90: mode = M_ID;
                    8'h98: mode = M_QRY;
                    8'hE8: begin st = st | 8'h80; mode = M_BCNT; end
                    default: mode = M_ARR;
                endcase
            end
            M_QRY: mode = M_ARR;
            M_PROG: begin
                if (!wp) mstore(a, d, s);
                st = st | 8'h80 | (wp ? 8'h10 : 8'h00);
                mode = M_STAT;
            end
            M_ERASE: begin
                if (c == 8'hD0) begin
                    if (!wp) for (int i = 0; i < 16; i++) mm[(a & 8'hF0) + 8'(i)] = 8'hFF;
                    st = st | 8'h80 | (wp ? 8'h20 : 8'h00);
                    mode = M_STAT;
                end else mode = M_ARR;
            end
            M_LOCK: begin
                if (c == 8'hD0 || c == 8'h01) begin st = st | 8'h80; mode = M_STAT; end
                else mode = M_ARR;
            end
            M_BCNT: begin cnt = int'(c); mode = M_BDATA; end
            M_BDATA: begin
                if (!wp) mstore(a, d, s);
                else st = st | 8'h10;
                if (cnt == 0) mode = M_BCONF;
                else cnt--;
            end
            M_BCONF: begin
                if (c == 8'hD0) begin st = st | 8'h80; mode = M_STAT; end
                else mode = M_ARR;
            end
            default: mode = M_ARR;
        endcase
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] s, input bit nsec);
        @(negedge clk);
        addr = a; wdata = d; size = s; ns = nsec; we = 1'b1;
        @(posedge clk);
        model_wr(a, d, int'(s), nsec);
        @(negedge clk);
        we = 1'b0; ns = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [2:0] s, input bit nsec, input string tag);
        @(negedge clk);
        addr = a; size = s; ns = nsec; re = 1'b1;
        @(posedge clk);
        exp_rd = model_rd(a, int'(s), nsec);
        @(negedge clk);
        re = 1'b0; ns = 1'b0;
        chk(rdata_o, exp_rd, tag);
    endtask

    task automatic rdk(input logic [7:0] a, input logic [2:0] s, input bit nsec,
                       input logic [31:0] lit, input string tag);
        rd(a, s, nsec, tag);
        chk(rdata_o, lit, tag);
    endtask

    // per-cycle comparison against the model: the output holds between reads
    always @(negedge clk) begin
        if (rst_n && !done) chk(rdata_o, exp_rd, "R13 hold");
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mm[i] = 8'hFF;
        mode = M_ARR; st = 8'h80; cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(rdata_o, 32'h0, "R1 rdata after reset");
        rdk(8'h00, 3'd4, 0, 32'hFFFF_FFFF, "R1 erased array");
        wr(8'h00, 32'h70, 3'd1, 0);
        rdk(8'h00, 3'd4, 0, 32'h8080_8080, "R1 status ready");
        rdk(8'h00, 3'd2, 0, 32'h0000_8080, "R8 status size2");
        rdk(8'h00, 3'd1, 0, 32'h0000_0080, "R8 status size1");

        // R2 program, little endian
        wr(8'h00, 32'h40, 3'd1, 0);
        wr(8'h10, 32'h1122_3344, 3'd4, 0);
        rdk(8'h10, 3'd4, 0, 32'h8080_8080, "R2 status after program");
        wr(8'h00, 32'hFF, 3'd1, 0);
        rdk(8'h10, 3'd4, 0, 32'h1122_3344, "R2 programmed word");
        rdk(8'h11, 3'd1, 0, 32'h0000_0033, "R12 byte lane little endian");
        wr(8'h00, 32'h10, 3'd1, 0);
        wr(8'h20, 32'hCAFE_0102, 3'd4, 0);
        wr(8'h00, 32'hF0, 3'd1, 0);

        // R12 big endian
        be = 1'b1;
        rdk(8'h10, 3'd4, 0, 32'h4433_2211, "R12 big endian read");
        wr(8'h00, 32'h40, 3'd1, 0);
        wr(8'h30, 32'h0000_A1B2, 3'd2, 0);
        wr(8'h00, 32'hFF, 3'd1, 0);
        rdk(8'h30, 3'd1, 0, 32'h0000_00A1, "R12 big endian store");
        rd(8'h30, 3'd2, 0, "R12 big endian halfword");
        be = 1'b0;
        rdk(8'h30, 3'd2, 0, 32'h0000_B2A1, "R12 little endian halfword");

        // R3 erase abort, then erase
        wr(8'h00, 32'h20, 3'd1, 0);
        wr(8'h13, 32'h55, 3'd1, 0);
        rdk(8'h10, 3'd4, 0, 32'h1122_3344, "R3 abort keeps data");
        wr(8'h00, 32'h28, 3'd1, 0);
        wr(8'h13, 32'hD0, 3'd1, 0);
        rdk(8'h00, 3'd4, 0, 32'h8080_8080, "R3 status after erase");
        wr(8'h00, 32'hFF, 3'd1, 0);
        rdk(8'h10, 3'd4, 0, 32'hFFFF_FFFF, "R3 sector erased");
        rdk(8'h20, 3'd4, 0, 32'hCAFE_0102, "R3 next sector kept");

        // R2/R3 with write protect
        wp = 1'b1;
        wr(8'h00, 32'h40, 3'd1, 0);
        wr(8'h20, 32'h0, 3'd4, 0);
        rdk(8'h00, 3'd1, 0, 32'h0000_0090, "R2 protect error bit");
        wr(8'h00, 32'h20, 3'd1, 0);
        wr(8'h20, 32'hD0, 3'd1, 0);
        rdk(8'h00, 3'd1, 0, 32'h0000_00B0, "R3 protect error bit");
        wr(8'h00, 32'hFF, 3'd1, 0);
        rdk(8'h20, 3'd4, 0, 32'hCAFE_0102, "R2 R3 protected array kept");
        wp = 1'b0;

        // R4 clear
        wr(8'h00, 32'h50, 3'd1, 0);
        rdk(8'h20, 3'd4, 0, 32'hCAFE_0102, "R4 clear returns to array");
        wr(8'h00, 32'h70, 3'd1, 0);
        rdk(8'h00, 3'd4, 0, 32'h0, "R4 status cleared");

        // R5 exits
        wr(8'h00, 32'hF0, 3'd1, 0);
        rdk(8'h20, 3'd4, 0, 32'hCAFE_0102, "R5 0xF0 to array");
        wr(8'h00, 32'h70, 3'd1, 0);
        wr(8'h00, 32'h33, 3'd1, 0);
        rdk(8'h20, 3'd4, 0, 32'hCAFE_0102, "R5 unknown to array");
        wr(8'h00, 32'h70, 3'd1, 0);
        wr(8'h00, 32'h00, 3'd1, 0);
        rd(8'h20, 3'd4, 0, "R5 0x00 to array");

        // R6 lock
        wr(8'h00, 32'h60, 3'd1, 0);
        wr(8'h00, 32'h01, 3'd1, 0);
        rdk(8'h00, 3'd1, 0, 32'h0000_0080, "R6 lock accepted");
        wr(8'h00, 32'h60, 3'd1, 0);
        wr(8'h00, 32'h33, 3'd1, 0);
        rdk(8'h20, 3'd4, 0, 32'hCAFE_0102, "R6 lock rejected");

        // R7 buffered write
        wr(8'h00, 32'hE8, 3'd1, 0);
        rdk(8'h00, 3'd1, 0, 32'h0000_0080, "R8 status in buffer state");
        wr(8'h00, 32'h0000_0102, 3'd1, 0);
        wr(8'h80, 32'hA0A1_A2A3, 3'd4, 0);
        wr(8'h84, 32'hB0B1_B2B3, 3'd4, 0);
        wr(8'h88, 32'hC0C1_C2C3, 3'd4, 0);
        wr(8'h00, 32'hD0, 3'd1, 0);
        rdk(8'h00, 3'd1, 0, 32'h0000_0080, "R7 confirm status");
        wr(8'h00, 32'hFF, 3'd1, 0);
        rdk(8'h88, 3'd4, 0, 32'hC0C1_C2C3, "R7 third word stored");
        rd(8'h84, 3'd4, 0, "R7 second word");
        wr(8'h00, 32'hE8, 3'd1, 0);
        wr(8'h00, 32'h0, 3'd1, 0);
        wr(8'h90, 32'h1357_9BDF, 3'd4, 0);
        wr(8'h00, 32'h77, 3'd1, 0);
        rdk(8'h90, 3'd4, 0, 32'h1357_9BDF, "R7 abort keeps data");

        // R9 identifier
        wr(8'h00, 32'h90, 3'd1, 0);
        rdk(8'h00, 3'd4, 0, 32'h8989_8989, "R9 manufacturer");
        rdk(8'h04, 3'd4, 0, 32'h1818_1818, "R9 device");
        rdk(8'h08, 3'd4, 0, 32'h0, "R9 other offset");

        // R10 query
        wr(8'h00, 32'h98, 3'd1, 0);
        rdk(8'h40, 3'd1, 0, 32'h51, "R10 Q");
        rdk(8'h44, 3'd1, 0, 32'h52, "R10 R");
        rdk(8'h48, 3'd1, 0, 32'h59, "R10 Y");
        rdk(8'h4C, 3'd1, 0, 32'h01, "R10 command set");
        rdk(8'h9C, 3'd1, 0, 32'h08, "R10 size code");
        rdk(8'hB0, 3'd2, 0, 32'h0101, "R10 region count");
        wr(8'h00, 32'h70, 3'd1, 0);
        rdk(8'h20, 3'd4, 0, 32'hCAFE_0102, "R10 any write leaves query");

        // R11 non-secure
        wr(8'h00, 32'h70, 3'd1, 0);
        rdk(8'h20, 3'd4, 1, 32'hCAFE_0102, "R11 nonsecure reads array");
        wr(8'h00, 32'hFF, 3'd1, 1);
        wr(8'h00, 32'h40, 3'd1, 1);
        wr(8'h20, 32'h0, 3'd4, 1);
        rdk(8'h00, 3'd1, 0, 32'h0000_0080, "R11 nonsecure write ignored");
        wr(8'h00, 32'hFF, 3'd1, 0);
        rdk(8'h20, 3'd4, 0, 32'hCAFE_0102, "R11 array untouched");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule